// File: doc/BRIEF.md
# Burst Memory Loopback and Matrix-Vector Controller

This block sequences one read burst and one write burst against an external memory through two simplified master channels: a read channel (request, then data beats) and a write channel (request, then data beats, then a completion response). Software sets a mode bit, the sizes and the two base addresses, then pulses start. The controller latches these values, fetches the words, and writes a result burst to the write base address.

With the mode bit clear it runs a self-test loopback. It reads a burst of words into an internal buffer and writes the same words back, unchanged and in order. With the mode bit set it computes a matrix-vector product. The first N fetched words form a vector that is kept in the buffer. The next N×N words stream through as a row-major matrix. Each completed row yields one dot product, and the N products are written back. The two modes share one state machine and the same burst counters.

Top module: `mlb_ctrl`

## Requirements
- R1: During and right after reset, `done`, `rd_req_valid`, `rd_data_ready`, `wr_req_valid` and `wr_data_valid` are all low.
- R2: A `start` pulse is accepted only while the controller is idle or done. A pulse during a run has no effect: no second request is issued and the run's addresses, lengths and data are unchanged.
- R3: The read request carries the latched read base and the read length, and the write request carries the latched write base and the write length. Each request holds its valid, address and length steady until its ready is seen.
- R4: A data beat moves only in a cycle where both valid and ready of its channel are high. `rd_data_ready` is high only in the read data phase, and `wr_data_valid` only in the write data phase. Exactly the requested number of beats moves on each channel.
- R5: In loopback mode (`mode`=0) with length L taken from `burst_len`, the read length and the write length are both L. Word k written to `wr_base+k` equals word k read from `rd_base+k`.
- R6: The write request is issued only after every requested read beat has been accepted.
- R7: In compute mode (`mode`=1) with N taken from `mat_size`, the read length is N+N·N and the write length is N. Read words 0..N-1 are vector v, and word N+i·N+j is matrix entry A[i][j]. Write word i is the sum over j of A[i][j]·v[j], modulo 2^DW.
- R8: A size above BUF_DEPTH (16 by default) is treated as BUF_DEPTH in both modes.
- R9: `done` rises one cycle after the write response that follows the last write beat. It stays high until a start with non-zero size is accepted, and falls in the next cycle.
- R10: A start whose selected size is zero raises `done` one cycle later and issues no read or write request.
- R11: Mode, sizes and base addresses are sampled only when start is accepted. Changing them during a run does not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| mode | input | 1 | 1 = matrix-vector compute, 0 = loopback |
| burst_len | input | LW | Loopback word count |
| mat_size | input | LW | Matrix dimension N |
| rd_base | input | AW | Read base address |
| wr_base | input | AW | Write base address |
| done | output | 1 | Run finished, held until next accepted start |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read burst start address |
| rd_req_len | output | 2·clog2(BUF_DEPTH+1) | Read burst word count |
| rd_data_valid | input | 1 | Read beat valid |
| rd_data_ready | output | 1 | Controller accepts read beat |
| rd_data | input | DW | Read beat data |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | AW | Write burst start address |
| wr_req_len | output | clog2(BUF_DEPTH+1) | Write burst word count |
| wr_data_valid | output | 1 | Write beat valid |
| wr_data_ready | input | 1 | Memory accepts write beat |
| wr_data | output | DW | Write beat data |
| wr_resp_valid | input | 1 | Write burst completion |

## Verification
The assertions are checked on every cycle. They cover request stability under backpressure, the rule that the read and write data phases never overlap, the write request waiting for the last read beat, `done` holding, the silence after a zero-size start, latched parameters ignoring a busy start, and the column and row counters of the dot-product engine staying inside N. Only the bench scenarios can show that the written words are correct. These include the loopback copy, the modular matrix-vector results under irregular valid and ready patterns, the clamping of oversized requests, and a run whose inputs are altered mid-flight yet still completes with its original values.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_DATA, ST_WR_REQ, ST_WR_DATA, ST_DONE
  } mlb_state_e;

  localparam logic MODE_LOOP    = 1'b0;
  localparam logic MODE_COMPUTE = 1'b1;
endpackage

// File: rtl/mlb_buf.sv
// Small word store: one synchronous write port, one combinational read port.
module mlb_buf #(
  parameter int DW        = 16,
  parameter int BUF_DEPTH = 16
) (
  input  logic                                                clk,
  input  logic                                                we,
  input  logic [((BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1)-1:0] waddr,
  input  logic [DW-1:0]                                       wdata,
  input  logic [((BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1)-1:0] raddr,
  output logic [DW-1:0]                                       rdata
);
  logic [DW-1:0] words [BUF_DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/mlb_mv.sv
// Streaming dot-product engine: one matrix word per beat, one result per row.
module mlb_mv #(
  parameter int DW        = 16,
  parameter int BUF_DEPTH = 16
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                clear,
  input  logic                                                beat,
  input  logic [DW-1:0]                                       mat_word,
  input  logic [$clog2(BUF_DEPTH+1)-1:0]                      n,
  output logic [((BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1)-1:0] vec_addr,
  input  logic [DW-1:0]                                       vec_word,
  output logic                                                res_we,
  output logic [((BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1)-1:0] res_addr,
  output logic [DW-1:0]                                       res_data
);
  localparam int CW = $clog2(BUF_DEPTH + 1);
  localparam int AB = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  function automatic logic [DW-1:0] mac(input logic [DW-1:0] acc,
                                        input logic [DW-1:0] a,
                                        input logic [DW-1:0] b);
    return acc + a * b;
  endfunction

  logic [CW-1:0] col_q, row_q;
  logic [DW-1:0] acc_q, acc_nx;
  logic          row_end;

  assign row_end  = (col_q == n - CW'(1));
  assign acc_nx   = mac((col_q == '0) ? '0 : acc_q, mat_word, vec_word);
  assign vec_addr = AB'(col_q);
  assign res_we   = beat && row_end;
  assign res_addr = AB'(row_q);
  assign res_data = acc_nx;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      col_q <= '0;
      row_q <= '0;
      acc_q <= '0;
    end else if (beat) begin
      acc_q <= acc_nx;
      if (row_end) begin
        col_q <= '0;
        row_q <= row_q + CW'(1);
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end

  // R7: the column index never reaches N while matrix words stream in
  a_r7_col_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (col_q < n));
  // R7: every result lands in one of the N result slots
  a_r7_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (row_q < n));
endmodule

// File: rtl/mlb_ctrl.sv
module mlb_ctrl #(
  parameter int AW        = 32,
  parameter int DW        = 16,
  parameter int LW        = 8,
  parameter int BUF_DEPTH = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 mode,
  input  logic [LW-1:0]                        burst_len,
  input  logic [LW-1:0]                        mat_size,
  input  logic [AW-1:0]                        rd_base,
  input  logic [AW-1:0]                        wr_base,
  output logic                                 done,
  output logic                                 rd_req_valid,
  input  logic                                 rd_req_ready,
  output logic [AW-1:0]                        rd_req_addr,
  output logic [2*$clog2(BUF_DEPTH+1)-1:0]     rd_req_len,
  input  logic                                 rd_data_valid,
  output logic                                 rd_data_ready,
  input  logic [DW-1:0]                        rd_data,
  output logic                                 wr_req_valid,
  input  logic                                 wr_req_ready,
  output logic [AW-1:0]                        wr_req_addr,
  output logic [$clog2(BUF_DEPTH+1)-1:0]       wr_req_len,
  output logic                                 wr_data_valid,
  input  logic                                 wr_data_ready,
  output logic [DW-1:0]                        wr_data,
  input  logic                                 wr_resp_valid
);
  import mlb_pkg::*;

  localparam int CW  = $clog2(BUF_DEPTH + 1);
  localparam int RLW = 2 * CW;
  localparam int AB  = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam logic [LW-1:0] DEPTH_L = LW'(BUF_DEPTH);

  // Size request clamped to what the buffers hold.
  function automatic logic [CW-1:0] clamp_len(input logic [LW-1:0] req);
    return (req > DEPTH_L) ? CW'(BUF_DEPTH) : CW'(req);
  endfunction

  // Words fetched per run: N in loopback, N + N*N in compute.
  function automatic logic [RLW-1:0] read_words(input logic m, input logic [CW-1:0] n);
    return (m == MODE_COMPUTE) ? (RLW'(n) + RLW'(n) * RLW'(n)) : RLW'(n);
  endfunction

  mlb_state_e     state_q, state_d;
  logic           mode_q;
  logic [CW-1:0]  n_q, wlen_q, wr_cnt;
  logic [RLW-1:0] rlen_q, rd_cnt;
  logic [AW-1:0]  rbase_q, wbase_q;

  // Named internal events
  logic          is_idle, start_ok, zero_len, rd_beat, wr_beat, rd_last;
  logic          wr_all_sent, vec_phase, buf_we, mv_beat;
  logic [CW-1:0] sel_len;

  assign is_idle     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign start_ok    = start && is_idle;
  assign sel_len     = clamp_len((mode == MODE_COMPUTE) ? mat_size : burst_len);
  assign zero_len    = (sel_len == '0);
  assign rd_beat     = rd_data_valid && rd_data_ready;
  assign wr_beat     = wr_data_valid && wr_data_ready;
  assign rd_last     = rd_beat && (rd_cnt == rlen_q - RLW'(1));
  assign wr_all_sent = (wr_cnt == wlen_q);
  assign vec_phase   = (rd_cnt < RLW'(n_q));
  assign buf_we      = rd_beat && ((mode_q == MODE_LOOP) || vec_phase);
  assign mv_beat     = rd_beat && (mode_q == MODE_COMPUTE) && !vec_phase;

  // Buffers and compute engine
  logic [DW-1:0] buf_rdata, res_rdata, res_wdata;
  logic [AB-1:0] vec_addr, buf_raddr, res_waddr;
  logic          res_we;

  assign buf_raddr = (state_q == ST_WR_DATA) ? AB'(wr_cnt) : vec_addr;

  mlb_buf #(.DW(DW), .BUF_DEPTH(BUF_DEPTH)) u_data_buf (
    .clk(clk), .we(buf_we), .waddr(AB'(rd_cnt)), .wdata(rd_data),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  mlb_mv #(.DW(DW), .BUF_DEPTH(BUF_DEPTH)) u_mv (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .beat(mv_beat),
    .mat_word(rd_data), .n(n_q), .vec_addr(vec_addr), .vec_word(buf_rdata),
    .res_we(res_we), .res_addr(res_waddr), .res_data(res_wdata)
  );

  mlb_buf #(.DW(DW), .BUF_DEPTH(BUF_DEPTH)) u_res_buf (
    .clk(clk), .we(res_we), .waddr(res_waddr), .wdata(res_wdata),
    .raddr(AB'(wr_cnt)), .rdata(res_rdata)
  );

  // Sequencer
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = zero_len ? ST_DONE : ST_RD_REQ;
      ST_RD_REQ:        if (rd_req_ready) state_d = ST_RD_DATA;
      ST_RD_DATA:       if (rd_last) state_d = ST_WR_REQ;
      ST_WR_REQ:        if (wr_req_ready) state_d = ST_WR_DATA;
      ST_WR_DATA:       if (wr_all_sent && wr_resp_valid) state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_LOOP;
      n_q     <= '0;
      wlen_q  <= '0;
      rlen_q  <= '0;
      rbase_q <= '0;
      wbase_q <= '0;
      rd_cnt  <= '0;
      wr_cnt  <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        mode_q  <= mode;
        n_q     <= sel_len;
        wlen_q  <= sel_len;
        rlen_q  <= read_words(mode, sel_len);
        rbase_q <= rd_base;
        wbase_q <= wr_base;
        rd_cnt  <= '0;
        wr_cnt  <= '0;
      end else begin
        if (rd_beat) rd_cnt <= rd_cnt + RLW'(1);
        if (wr_beat) wr_cnt <= wr_cnt + CW'(1);
      end
    end
  end

  assign done          = (state_q == ST_DONE);
  assign rd_req_valid  = (state_q == ST_RD_REQ);
  assign rd_req_addr   = rbase_q;
  assign rd_req_len    = rlen_q;
  assign rd_data_ready = (state_q == ST_RD_DATA);
  assign wr_req_valid  = (state_q == ST_WR_REQ);
  assign wr_req_addr   = wbase_q;
  assign wr_req_len    = wlen_q;
  assign wr_data_valid = (state_q == ST_WR_DATA) && !wr_all_sent;
  assign wr_data       = (mode_q == MODE_COMPUTE) ? res_rdata : buf_rdata;

  // R3: read request held steady under backpressure
  a_r3_rdreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)));
  // R3: write request held steady under backpressure
  a_r3_wrreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=> (wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_len)));
  // R4: read and write data phases never overlap
  a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data_ready && wr_data_valid));
  // R4: accepted read beats never exceed the request
  a_r4_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= rlen_q);
  // R6: write request only once all read beats are in
  a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid |-> (rd_cnt == rlen_q));
  // R9: done holds until a start arrives
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R10: zero-size start finishes without a request
  a_r10_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && zero_len) |=> (done && !rd_req_valid && !wr_req_valid));
  // R2: start while busy leaves the latched run parameters alone
  a_r2_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_idle) |=> ($stable(rbase_q) && $stable(wbase_q) && $stable(mode_q) && $stable(rlen_q)));
endmodule

// File: tb/sim_mlb_ctrl.sv
module sim_mlb_ctrl;
  localparam int AW = 32, DW = 16, LW = 8, DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1), RLW = 2 * CW;
  localparam int MSZ = 512;

  // Stimulus / expected table: mode, size, rd base, wr base, stall, exp rd len, exp wr len
  localparam int NV = 6;
  localparam int T_MODE [NV] = '{0, 0, 1, 1, 0, 1};
  localparam int T_SIZE [NV] = '{5, 16, 3, 4, 40, 20};
  localparam int T_RB   [NV] = '{16, 40, 0, 64, 100, 0};
  localparam int T_WB   [NV] = '{200, 300, 400, 420, 450, 470};
  localparam int T_ST   [NV] = '{0, 1, 0, 1, 1, 1};
  localparam int T_RLEN [NV] = '{5, 16, 12, 20, 16, 272};
  localparam int T_WLEN [NV] = '{5, 16, 3, 4, 16, 16};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, mode = 0;
  logic [LW-1:0] burst_len = '0, mat_size = '0;
  logic [AW-1:0] rd_base = '0, wr_base = '0;
  logic done, rd_req_valid, rd_data_ready, wr_req_valid, wr_data_valid;
  logic rd_req_ready = 0, rd_data_valid = 0, wr_req_ready = 0, wr_data_ready = 0, wr_resp_valid = 0;
  logic [AW-1:0] rd_req_addr, wr_req_addr;
  logic [RLW-1:0] rd_req_len;
  logic [CW-1:0] wr_req_len;
  logic [DW-1:0] rd_data = '0, wr_data;

  mlb_ctrl #(.AW(AW), .DW(DW), .LW(LW), .BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .burst_len(burst_len),
    .mat_size(mat_size), .rd_base(rd_base), .wr_base(wr_base), .done(done),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_req_len(rd_req_len), .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready),
    .rd_data(rd_data), .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_len(wr_req_len), .wr_data_valid(wr_data_valid),
    .wr_data_ready(wr_data_ready), .wr_data(wr_data), .wr_resp_valid(wr_resp_valid)
  );

  // Memory model: owns mem and all counters; acts at falling edges.
  logic [DW-1:0] mem [MSZ];
  int stall = 0, init_tok = 0, init_seed = 0, seen_tok = 0, cyc = 0;
  int rd_ptr = 0, rd_left = 0, wr_ptr = 0, wr_left = 0;
  logic rd_act = 0, p_rdreq = 0, p_rdbeat = 0, p_wrreq = 0, p_wrbeat = 0;
  logic [DW-1:0] p_wdata = '0;
  int p_raddr = 0, p_rlen = 0, p_waddr = 0, p_wlen = 0;
  int n_rdreq = 0, n_wrreq = 0, n_rdbeat = 0, n_wrbeat = 0, n_rdvalid = 0;
  int rq_addr = 0, rq_len = 0, wq_addr = 0, wq_len = 0, last_rd_cyc = 0, wrreq_cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (init_tok != seen_tok) begin
      for (int k = 0; k < MSZ; k++) mem[k] = DW'(k * 29 + init_seed * 7 + 3);
      seen_tok = init_tok;
    end
    if (p_rdreq) begin
      rd_act = 1; rd_ptr = p_raddr; rd_left = p_rlen; n_rdreq++; rq_addr = p_raddr; rq_len = p_rlen;
    end
    if (p_rdbeat) begin
      rd_ptr++; rd_left--; n_rdbeat++; last_rd_cyc = cyc;
      if (rd_left == 0) rd_act = 0;
    end
    if (p_wrreq) begin
      wr_ptr = p_waddr; wr_left = p_wlen; n_wrreq++; wq_addr = p_waddr; wq_len = p_wlen; wrreq_cyc = cyc;
    end
    wr_resp_valid = 0;
    if (p_wrbeat) begin
      mem[wr_ptr % MSZ] = p_wdata; wr_ptr++; wr_left--; n_wrbeat++;
      if (wr_left == 0) wr_resp_valid = 1;
    end
    rd_req_ready  = (stall != 0) ? (cyc % 3 == 0) : 1'b1;
    wr_req_ready  = (stall != 0) ? (cyc % 4 == 1) : 1'b1;
    rd_data_valid = rd_act && (rd_left > 0) && ((stall != 0) ? (cyc % 3 != 1) : 1'b1);
    rd_data       = mem[rd_ptr % MSZ];
    wr_data_ready = (stall != 0) ? (cyc % 5 != 2 && cyc % 5 != 3) : 1'b1;
    p_rdreq  = rst_n && rd_req_valid && rd_req_ready;
    p_raddr  = int'(rd_req_addr);
    p_rlen   = int'(rd_req_len);
    p_rdbeat = rst_n && rd_data_valid && rd_data_ready;
    p_wrreq  = rst_n && wr_req_valid && wr_req_ready;
    p_waddr  = int'(wr_req_addr);
    p_wlen   = int'(wr_req_len);
    p_wrbeat = rst_n && wr_data_valid && wr_data_ready;
    p_wdata  = wr_data;
    if (rd_req_valid || wr_req_valid) n_rdvalid++;
  end

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_mem(input int seed);
    init_seed = seed;
    init_tok++;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 6000) begin @(negedge clk); t++; end
  endtask

  task automatic run_case(input int idx);
    logic [DW-1:0] exp [DEPTH];
    logic [DW-1:0] acc, sent;
    int rb, wb, wl, b_rq, b_wq, b_rb, b_wb;
    string tg;
    rb = T_RB[idx]; wb = T_WB[idx]; wl = T_WLEN[idx];
    tg = (T_MODE[idx] != 0) ? "R7" : "R5";
    stall = T_ST[idx];
    load_mem(idx + 1);
    for (int i = 0; i < wl; i++) begin
      if (T_MODE[idx] == 0) exp[i] = mem[rb + i];
      else begin
        acc = '0;
        for (int j = 0; j < wl; j++) acc = acc + mem[rb + wl + i * wl + j] * mem[rb + j];
        exp[i] = acc;
      end
    end
    sent = mem[wb + wl];
    b_rq = n_rdreq; b_wq = n_wrreq; b_rb = n_rdbeat; b_wb = n_wrbeat;
    mode = T_MODE[idx][0];
    if (T_MODE[idx] != 0) begin mat_size = LW'(T_SIZE[idx]); burst_len = LW'(2); end
    else begin burst_len = LW'(T_SIZE[idx]); mat_size = LW'(7); end
    rd_base = AW'(rb); wr_base = AW'(wb);
    start = 1; @(negedge clk); start = 0;
    wait_done();
    chk(done, "R9 run reaches done", int'(done), 1);
    chk(n_rdreq - b_rq == 1 && n_wrreq - b_wq == 1, "R3 one request per channel", n_rdreq - b_rq, 1);
    chk(rq_addr == rb, "R3 read address", rq_addr, rb);
    chk(wq_addr == wb, "R3 write address", wq_addr, wb);
    chk(rq_len == T_RLEN[idx], {tg, " R8 read length"}, rq_len, T_RLEN[idx]);
    chk(wq_len == wl, {tg, " R8 write length"}, wq_len, wl);
    chk(n_rdbeat - b_rb == T_RLEN[idx], "R4 read beats", n_rdbeat - b_rb, T_RLEN[idx]);
    chk(n_wrbeat - b_wb == wl, "R4 write beats", n_wrbeat - b_wb, wl);
    chk(wrreq_cyc > last_rd_cyc, "R6 write after reads", wrreq_cyc, last_rd_cyc + 1);
    for (int i = 0; i < wl; i++)
      chk(mem[wb + i] == exp[i], {tg, " result word"}, int'(mem[wb + i]), int'(exp[i]));
    chk(mem[wb + wl] == sent, "R4 no write past burst", int'(mem[wb + wl]), int'(sent));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int b_v;
    logic [DW-1:0] e6 [6];
    logic [DW-1:0] s6;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done && !rd_req_valid && !rd_data_ready && !wr_req_valid && !wr_data_valid,
        "R1 outputs low in reset", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !rd_req_valid && !wr_req_valid, "R1 idle after reset", int'(rd_req_valid), 0);

    // R10: zero loopback size from idle
    b_v = n_rdvalid;
    mode = 0; burst_len = '0; start = 1; @(negedge clk); start = 0;
    chk(done, "R10 zero size done next cycle", int'(done), 1);
    repeat (4) @(negedge clk);
    chk(n_rdvalid == b_v, "R10 no request for zero size", n_rdvalid - b_v, 0);
    // R10: zero compute size from done
    mode = 1; mat_size = '0; burst_len = LW'(9); start = 1; @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    chk(done && n_rdvalid == b_v, "R10 zero compute size quiet", n_rdvalid - b_v, 0);

    // Table-driven runs: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) run_case(v);

    // R9: done held, cleared by accepted non-zero start
    repeat (6) @(negedge clk);
    chk(done, "R9 done held while idle", int'(done), 1);

    // R2 / R11: busy start and input changes mid-run are ignored
    stall = 1;
    load_mem(11);
    for (int i = 0; i < 6; i++) e6[i] = mem[i];
    s6 = mem[306];
    mode = 0; burst_len = LW'(6); rd_base = AW'(0); wr_base = AW'(300);
    start = 1; @(negedge clk); start = 0;
    chk(!done, "R9 done falls after start", int'(done), 0);
    repeat (3) @(negedge clk);
    mode = 1; burst_len = LW'(9); mat_size = LW'(2); rd_base = AW'(50); wr_base = AW'(350);
    start = 1; @(negedge clk); start = 0;
    wait_done();
    chk(rq_addr == 0 && rq_len == 6, "R2 R11 read request unchanged", rq_len, 6);
    chk(wq_addr == 300 && wq_len == 6, "R11 write request unchanged", wq_addr, 300);
    for (int i = 0; i < 6; i++)
      chk(mem[300 + i] == e6[i], "R2 R11 loopback data intact", int'(mem[300 + i]), int'(e6[i]));
    chk(mem[306] == s6, "R11 length not extended", int'(mem[306]), int'(s6));
    repeat (6) @(negedge clk);
    chk(done && !rd_req_valid && !rd_data_ready, "R2 no second run", int'(rd_req_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule